// File: doc/BRIEF.md
# Three-Pulse Bus Request/Grant Arbiter

This block is the processor-side controller for a single-wire, active-low request/grant handshake shared with up to `LINES` other local bus masters (two by default). Each master owns one open-drain line. A master asks for the bus with a one-clock low pulse. The processor answers on the same wire with its own one-clock low pulse (the grant), floats the bus, and waits for a third one-clock pulse from that master (the release). After the release it leaves one dead clock before it takes the bus back.

The arbiter does not sequence bus cycles itself. It observes the processor's T-state, the attributes of the current cycle (low half of a word at an odd address, first interrupt acknowledge, locked instruction), a bus-idle flag and a flag saying a memory cycle is about to start. From these it decides in which clock the bus may be given away. Its outputs are one pull-low enable per line and a `bus_float` level that tells the bus drivers to go to high impedance. The handshake carries only control, so every pin is a plain level sampled on the rising clock edge, with no valid/ready flow control.

T-state codes on `tstate`: 0 idle, 1 T1, 2 T2, 3 T3, 4 T4, 5 wait state. A line reads low when any master, including this processor, pulls it.

Top module: `rqg_arbiter`

## Requirements
- R1: While `rst_n` is low and in the first clock after it rises, `pull_low` is all zeros and `bus_float` is low.
- R2: With `tstate`=0, `bus_idle`=1, `cyc_pending`=0 and `locked`=0, a line held low for one clock gets its `pull_low` bit (bit i for line i) high in exactly the next clock and low again in the clock after.
- R3: `bus_float` goes high in the grant clock, stays high up to and including the clock in which the holder's release pulse is on its line, and is low in the clock after that pulse.
- R4: The clock after the release pulse is a dead clock: no grant is issued in it or in the clock that follows. A request pending or arriving in the dead clock, with the bus idle, is granted in the third clock after the release pulse.
- R5: When lines request in the same clock, the lowest index (line 0) is granted; the other request stays pending and is served after the exchange ends.
- R6: A low pulse on a line other than the holder's while the bus is given away is not answered then, is remembered, and is served after the dead clock.
- R7: During an active cycle (codes 1 to 5), a request seen in a clock with code 0, 1 or 2 is granted in the clock right after the T4 (code 4) clock, when the cycle attributes allow it.
- R8: A request first seen in a clock with code 3, 4 or 5 is not granted after that cycle's T4; it is granted after the T4 of the next cycle.
- R9: If `odd_low` or `first_inta` is high in the T4 clock, no grant follows that T4; the request stays pending for a later T4.
- R10: While `locked` is high no grant is issued in the next clock; once it drops, a pending request is granted under the other rules.
- R11: With `tstate`=0, `bus_idle`=1 and `cyc_pending`=1 no grant is issued in the idle clock; the cycle that follows treats the request as made before T2 and grants after its T4.
- R12: At most one `pull_low` bit is ever high, and only in a grant clock; in every other clock the arbiter leaves all lines undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_n | input | LINES | Sampled level of each request/grant line, low = pulse |
| tstate | input | 3 | Current T-state code (0 idle, 1 T1, 2 T2, 3 T3, 4 T4, 5 wait) |
| bus_idle | input | 1 | No bus cycle is running |
| cyc_pending | input | 1 | A memory cycle will start within three clocks |
| odd_low | input | 1 | Current cycle is the first byte of a word at an odd address |
| first_inta | input | 1 | Current cycle is the first interrupt acknowledge |
| locked | input | 1 | A locked instruction is executing |
| pull_low | output | LINES | Pull-low enable per line, high only in the grant clock |
| bus_float | output | 1 | Bus released to another master |

## Verification
The bench targets the clock windows around each pulse: a grant one clock late or two clocks wide shows up as a mismatch on `pull_low`, and a missing dead clock shows up as a grant in the clock right after the release pulse. It lands requests in T2 and in T3 of a running cycle, so a design that ignores the early-request rule grants one cycle too soon or too late. It drives two lines in the same clock and pulses the second line while the first holds the bus; a design that loses the losing request never grants line 1, and one that answers it at once drives two lines. It blocks T4 with the odd-word and first-acknowledge flags in turn and holds `locked` across an idle request, where a design that skips any of these gates grants early.

// File: rtl/rqg_pkg.sv
package rqg_pkg;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_T4   = 3'd4,
    TS_TW   = 3'd5
  } tstate_e;

  typedef enum logic [1:0] {
    XS_OWN,
    XS_GRANT,
    XS_HELD,
    XS_DEAD
  } xchg_e;

endpackage

// File: rtl/rqg_req_latch.sv
module rqg_req_latch #(
  parameter int LINES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_n,
  input  logic [LINES-1:0] listen,
  input  logic [LINES-1:0] clr,
  output logic [LINES-1:0] req_now
);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic seen;
    logic pend_q;

    assign seen       = listen[i] & ~line_n[i];
    assign req_now[i] = pend_q | seen;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q <= 1'b0;
      else if (clr[i]) pend_q <= 1'b0;
      else if (seen)   pend_q <= 1'b1;
    end

    // R6: a remembered request survives until its own grant
    a_r6_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !clr[i]) |=> pend_q);
  end

endmodule

// File: rtl/rqg_pick.sv
module rqg_pick #(
  parameter int LINES = 2,
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic [LINES-1:0] req,
  output logic [LINES-1:0] sel,
  output logic [IW-1:0]    idx
);

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    sel = '0;
    idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (req[i]) begin
        sel    = '0;
        sel[i] = 1'b1;
        idx    = IW'(i);
      end
    end
  end

endmodule

// File: rtl/rqg_release_rules.sv
module rqg_release_rules
  import rqg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  tstate_e tstate,
  input  logic    bus_idle,
  input  logic    cyc_pending,
  input  logic    odd_low,
  input  logic    first_inta,
  input  logic    locked,
  input  logic    own,
  input  logic    any_req,
  input  logic    take,
  output logic    grant_ok
);

  logic early_q;
  logic addr_phase;
  logic idle_free;
  logic cycle_end_ok;

  assign addr_phase = (tstate == TS_IDLE) || (tstate == TS_T1) || (tstate == TS_T2);

  // request present no later than T2 of the cycle that ends in T4
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               early_q <= 1'b0;
    else if (take || (own && tstate == TS_T4)) early_q <= 1'b0;
    else if (own && any_req && addr_phase)     early_q <= 1'b1;
  end

  assign idle_free    = (tstate == TS_IDLE) && bus_idle && !cyc_pending;
  assign cycle_end_ok = (tstate == TS_T4) && early_q && !odd_low && !first_inta;
  assign grant_ok     = own && any_req && !locked && (idle_free || cycle_end_ok);

  // R8: the early flag never outlives a T4 seen while owning the bus
  a_r8_early_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (own && tstate == TS_T4) |=> !early_q);

endmodule

// File: rtl/rqg_exchange_fsm.sv
module rqg_exchange_fsm
  import rqg_pkg::*;
#(
  parameter int LINES = 2,
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_n,
  input  logic             grant_ok,
  input  logic [LINES-1:0] pick_sel,
  input  logic [IW-1:0]    pick_idx,
  output logic             own,
  output logic             take,
  output logic [LINES-1:0] listen,
  output logic [LINES-1:0] clr,
  output logic [LINES-1:0] pull_low,
  output logic             bus_float
);

  xchg_e           st_q;
  logic [IW-1:0]   hold_q;
  logic [LINES-1:0] hold_oh;
  logic            release_seen;

  assign hold_oh      = LINES'(1) << hold_q;
  assign own          = (st_q == XS_OWN);
  assign take         = own && grant_ok;
  assign release_seen = (st_q == XS_HELD) && !line_n[hold_q];
  assign listen       = ((st_q == XS_GRANT) || (st_q == XS_HELD)) ? ~hold_oh : '1;
  assign clr          = take ? pick_sel : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= XS_OWN;
      hold_q <= '0;
    end else begin
      unique case (st_q)
        XS_OWN: begin
          if (take) begin
            st_q   <= XS_GRANT;
            hold_q <= pick_idx;
          end
        end
        XS_GRANT: st_q <= XS_HELD;
        XS_HELD:  if (release_seen) st_q <= XS_DEAD;
        XS_DEAD:  st_q <= XS_OWN;
        default:  st_q <= XS_OWN;
      endcase
    end
  end

  assign pull_low  = (st_q == XS_GRANT) ? hold_oh : '0;
  assign bus_float = (st_q == XS_GRANT) || (st_q == XS_HELD);

  // R12: never more than one line pulled
  a_r12_single_pull: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pull_low));

  // R2: the grant pulse is one clock wide
  a_r2_grant_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (|pull_low) |=> (pull_low == '0));

  // R3: the bus stays released after the grant clock
  a_r3_float_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (|pull_low) |=> bus_float);

  // R3: held until the holder pulses its line
  a_r3_hold_until_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == XS_HELD && line_n[hold_q]) |=> bus_float);

  // R4: no grant in the clock after the dead clock
  a_r4_dead_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_float) |=> (pull_low == '0));

endmodule

// File: rtl/rqg_arbiter.sv
module rqg_arbiter
  import rqg_pkg::*;
#(
  parameter int LINES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_n,
  input  logic [2:0]       tstate,
  input  logic             bus_idle,
  input  logic             cyc_pending,
  input  logic             odd_low,
  input  logic             first_inta,
  input  logic             locked,
  output logic [LINES-1:0] pull_low,
  output logic             bus_float
);

  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1;

  tstate_e          ts;
  logic [LINES-1:0] listen;
  logic [LINES-1:0] clr;
  logic [LINES-1:0] req_now;
  logic [LINES-1:0] pick_sel;
  logic [IW-1:0]    pick_idx;
  logic             own;
  logic             take;
  logic             grant_ok;

  assign ts = tstate_e'(tstate);

  rqg_req_latch #(.LINES(LINES)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_n  (line_n),
    .listen  (listen),
    .clr     (clr),
    .req_now (req_now)
  );

  rqg_pick #(.LINES(LINES)) u_pick (
    .req (req_now),
    .sel (pick_sel),
    .idx (pick_idx)
  );

  rqg_release_rules u_rules (
    .clk         (clk),
    .rst_n       (rst_n),
    .tstate      (ts),
    .bus_idle    (bus_idle),
    .cyc_pending (cyc_pending),
    .odd_low     (odd_low),
    .first_inta  (first_inta),
    .locked      (locked),
    .own         (own),
    .any_req     (|req_now),
    .take        (take),
    .grant_ok    (grant_ok)
  );

  rqg_exchange_fsm #(.LINES(LINES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_n    (line_n),
    .grant_ok  (grant_ok),
    .pick_sel  (pick_sel),
    .pick_idx  (pick_idx),
    .own       (own),
    .take      (take),
    .listen    (listen),
    .clr       (clr),
    .pull_low  (pull_low),
    .bus_float (bus_float)
  );

  // R2 / R5: an idle request on line 0 is answered on line 0 next clock
  a_r2_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (own && ts == TS_IDLE && bus_idle && !cyc_pending && !locked && !line_n[0])
      |=> pull_low[0]);

  // R10: locked instruction holds off any grant
  a_r10_locked_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (pull_low == '0));

  // R9: blocked T4 never leads to a grant
  a_r9_blocked_t4: assert property (@(posedge clk) disable iff (!rst_n)
    (ts == TS_T4 && (odd_low || first_inta)) |=> (pull_low == '0));

endmodule

// File: tb/rqg_arbiter_tb.sv
module rqg_arbiter_tb;

  localparam int LINES = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [LINES-1:0] ext_low = '0;
  logic [LINES-1:0] line_n;
  logic [LINES-1:0] pull_low;
  logic             bus_float;
  logic [2:0]       tstate = 3'd0;
  logic             bus_idle = 1'b1;
  logic             cyc_pending = 1'b0;
  logic             odd_low = 1'b0;
  logic             first_inta = 1'b0;
  logic             locked = 1'b0;

  // open-drain wire with pull-up
  assign line_n = ~(ext_low | pull_low);

  rqg_arbiter #(.LINES(LINES)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_n      (line_n),
    .tstate      (tstate),
    .bus_idle    (bus_idle),
    .cyc_pending (cyc_pending),
    .odd_low     (odd_low),
    .first_inta  (first_inta),
    .locked      (locked),
    .pull_low    (pull_low),
    .bus_float   (bus_float)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int               at;
    logic [LINES-1:0] pull;
    logic             flt;
    string            tag;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  task automatic expect_at(input int at, input logic [LINES-1:0] p,
                           input logic f, input string tag);
    exp_t e;
    e.at = at; e.pull = p; e.flt = f; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare outputs in the clock each entry names
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        checks++;
        if (pull_low !== sb[i].pull || bus_float !== sb[i].flt) begin
          fails++;
          $display("FAIL %s @%0d: pull=%b float=%b expected pull=%b float=%b",
                   sb[i].tag, cyc, pull_low, bus_float, sb[i].pull, sb[i].flt);
        end
        sb.delete(i);
      end else if (sb[i].at < cyc) begin
        checks++;
        fails++;
        $display("FAIL %s: slot %0d missed, actual=none expected=compare",
                 sb[i].tag, sb[i].at);
        sb.delete(i);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse(input int line);
    ext_low[line] = 1'b1;
    tick();
    ext_low[line] = 1'b0;
  endtask

  task automatic set_t(input logic [2:0] code);
    tstate   = code;
    bus_idle = (code == 3'd0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    int c;
    int d;
    int e;

    // R1: reset state
    tick();
    expect_at(cyc + 1, 2'b00, 1'b0, "R1 in reset");
    tick(); tick();
    rst_n = 1'b1;
    expect_at(cyc + 1, 2'b00, 1'b0, "R1 first clock after reset");
    tick(); tick();

    // R2, R3, R4: idle request, release, request in the dead clock
    c = cyc;
    expect_at(c + 1, 2'b01, 1'b1, "R2 grant line0 next clock");
    expect_at(c + 2, 2'b00, 1'b1, "R2/R12 grant one clock wide");
    pulse(0);
    tick(); tick();
    expect_at(cyc + 1, 2'b00, 1'b1, "R3 bus stays released");
    tick();
    d = cyc;
    expect_at(d + 1, 2'b00, 1'b0, "R3 float drops after release");
    expect_at(d + 2, 2'b00, 1'b0, "R4 no grant after dead clock");
    expect_at(d + 3, 2'b10, 1'b1, "R4 dead-clock request served");
    pulse(0);
    pulse(1);
    tick(); tick();
    expect_at(cyc + 1, 2'b00, 1'b0, "R3 release of line1");
    pulse(1);
    tick(); tick();

    // R5: simultaneous requests
    c = cyc;
    ext_low = 2'b11;
    expect_at(c + 1, 2'b01, 1'b1, "R5 line0 wins");
    expect_at(c + 2, 2'b00, 1'b1, "R5 loser not granted while held");
    tick();
    ext_low = 2'b00;
    tick(); tick();
    d = cyc;
    expect_at(d + 1, 2'b00, 1'b0, "R3 float drops");
    expect_at(d + 2, 2'b00, 1'b0, "R4 dead window");
    expect_at(d + 3, 2'b10, 1'b1, "R5 loser served after exchange");
    pulse(0);
    tick(); tick(); tick();
    pulse(1);
    tick(); tick();

    // R6: request from the other line while the bus is given away
    c = cyc;
    expect_at(c + 1, 2'b01, 1'b1, "R6 line0 granted");
    pulse(0);
    tick();
    e = cyc;
    expect_at(e + 1, 2'b00, 1'b1, "R6 no answer while held");
    expect_at(e + 2, 2'b00, 1'b1, "R6 still held");
    pulse(1);
    tick();
    d = cyc;
    expect_at(d + 1, 2'b00, 1'b0, "R3 float drops");
    expect_at(d + 2, 2'b00, 1'b0, "R4 dead window");
    expect_at(d + 3, 2'b10, 1'b1, "R6 remembered request served");
    pulse(0);
    tick(); tick(); tick();
    pulse(1);
    tick(); tick();

    // R7: request in T2 granted after T4
    set_t(3'd1);
    tick();
    set_t(3'd2);
    ext_low[1] = 1'b1;
    tick();
    ext_low = '0;
    set_t(3'd3);
    expect_at(cyc + 1, 2'b00, 1'b0, "R7 no grant before T4");
    tick();
    set_t(3'd4);
    expect_at(cyc + 1, 2'b10, 1'b1, "R7 grant after T4");
    tick();
    set_t(3'd0);
    tick();
    pulse(1);
    tick(); tick(); tick();

    // R8: request in T3 waits for the next cycle
    set_t(3'd1); tick();
    set_t(3'd2); tick();
    set_t(3'd3);
    ext_low[0] = 1'b1;
    tick();
    ext_low = '0;
    set_t(3'd4);
    expect_at(cyc + 1, 2'b00, 1'b0, "R8 late request skipped");
    tick();
    set_t(3'd1); tick();
    set_t(3'd2); tick();
    set_t(3'd3); tick();
    set_t(3'd4);
    expect_at(cyc + 1, 2'b01, 1'b1, "R8 served after next T4");
    tick();
    set_t(3'd0);
    tick();
    pulse(0);
    tick(); tick(); tick();

    // R9: odd-word then first-acknowledge block T4
    for (int k = 0; k < 3; k++) begin
      odd_low    = (k == 0);
      first_inta = (k == 1);
      set_t(3'd1);
      if (k == 0) ext_low[1] = 1'b1;
      tick();
      ext_low = '0;
      set_t(3'd2); tick();
      set_t(3'd3); tick();
      set_t(3'd4);
      if (k < 2) expect_at(cyc + 1, 2'b00, 1'b0, "R9 blocked T4");
      else       expect_at(cyc + 1, 2'b10, 1'b1, "R9 granted on clean T4");
      tick();
    end
    odd_low = 1'b0;
    first_inta = 1'b0;
    set_t(3'd0);
    tick();
    pulse(1);
    tick(); tick(); tick();

    // R10: locked instruction
    locked = 1'b1;
    c = cyc;
    expect_at(c + 1, 2'b00, 1'b0, "R10 locked holds off");
    expect_at(c + 2, 2'b00, 1'b0, "R10 locked holds off");
    expect_at(c + 3, 2'b00, 1'b0, "R10 locked holds off");
    pulse(0);
    tick(); tick();
    locked = 1'b0;
    expect_at(cyc + 1, 2'b01, 1'b1, "R10 granted after unlock");
    tick(); tick();
    pulse(0);
    tick(); tick(); tick();

    // R11: idle but a cycle is about to start
    tstate = 3'd0;
    bus_idle = 1'b1;
    cyc_pending = 1'b1;
    ext_low[1] = 1'b1;
    expect_at(cyc + 1, 2'b00, 1'b0, "R11 no idle grant");
    tick();
    ext_low = '0;
    cyc_pending = 1'b0;
    set_t(3'd1); tick();
    set_t(3'd2); tick();
    set_t(3'd3); tick();
    set_t(3'd4);
    expect_at(cyc + 1, 2'b10, 1'b1, "R11 granted after T4");
    tick();
    set_t(3'd0);
    tick();
    pulse(1);
    tick(); tick(); tick();

    if (sb.size() != 0) begin
      fails += sb.size();
      checks += sb.size();
      $display("FAIL R12: %0d expectations left, actual=%0d expected=0", sb.size(), sb.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1-scope run: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule